// File: doc/BRIEF.md
# Modem Status Delta Tracker

This block produces the 8-bit modem status value of a serial port. It derives the four current line states (clear-to-send, data-set-ready, ring indicator and carrier detect) from the modem control value and from the external lines. It compares each new set of states with the previous one and latches change flags. The flags stay set until software reads the status. A single delta-pending output tells the interrupt logic that at least one flag is set.

In loopback mode the four control outputs of the modem control value feed the status states, and the external lines are ignored. Outside loopback, data-set-ready and carrier detect always read as asserted. Only the clear-to-send and ring-indicator lines are therefore brought in as ports. Ring indicator is the exception among the flags: its flag is raised only when the ring ends, that is when the line goes from asserted to deasserted.

A small state machine orders the work. In `ST_SEED`, the single cycle after reset, the register takes the current states with every flag clear. The transition `SEED_TO_RUN` is taken unconditionally at that edge. `ST_RUN` then recomputes the states on every clock, so a control write or a line change is seen on the next edge. `ST_RUN` holds through the transition `RUN_HOLD` until reset.

Top module: `msd_tracker`

## Requirements
- R1: While reset is asserted, `msr_o` is 0x00 and `delta_pend_o` is 0. On the first clock edge after reset the upper nibble takes the current line states and bits 3:0 stay 0.
- R2: Status layout: bit 4 is clear-to-send, bit 5 data-set-ready, bit 6 ring indicator and bit 7 carrier detect. With loopback off (`mctl_i[4]`=0), bit 4 follows `line_cts_i`, bit 6 follows `line_ri_i`, and bits 5 and 7 read 1.
- R3: With loopback on (`mctl_i[4]`=1), bit 4 = `mctl_i[1]`, bit 5 = `mctl_i[0]`, bit 6 = `mctl_i[2]` and bit 7 = `mctl_i[3]`. The external lines have no effect.
- R4: A change in either direction of bit 4, 5 or 7 sets flag bit 0, 1 or 3 respectively at the same edge that shows the new state.
- R5: Flag bit 2 is set only when bit 6 goes from 1 to 0. A rise of bit 6 sets no flag.
- R6: Flags are sticky. Once set, a flag stays 1 through later state changes until a read.
- R7: A cycle with `stat_rd_i`=1 clears all four flags at the next edge. A change detected in that same cycle still sets its flag.
- R8: `delta_pend_o` is 1 exactly when any of `msr_o[3:0]` is 1.
- R9: Entering or leaving loopback is a status change like any other and raises flags by R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mctl_i | input | 5 | Modem control: [0] terminal ready, [1] request to send, [2] aux out 1, [3] aux out 2, [4] loopback |
| line_cts_i | input | 1 | External clear-to-send state, active high |
| line_ri_i | input | 1 | External ring-indicator state, active high |
| stat_rd_i | input | 1 | Status read strobe, one cycle per read |
| msr_o | output | 8 | Modem status: [7:4] line states, [3:0] change flags |
| delta_pend_o | output | 1 | Any change flag set |

## Verification
Directed sequences start from seeding after reset. They then drop and raise the ring line, to tell a trailing-edge flag from a plain change detector. They pair a clear-to-send change with a read in the same cycle, to separate the read clear from the new flag. They switch into loopback with all control outputs low, which shows the forced-high states falling, and toggle the external lines while in loopback to show that those lines are ignored. Seeded random stimulus then mixes line toggles, control writes, loopback switches and reads at a mixed rate. An independent bench model compares the full status byte and the pending flag on every cycle, which exposes lost sticky flags and wrong bit mapping.

// File: rtl/msd_pkg.sv
package msd_pkg;
    localparam int LINES   = 4;
    localparam int MSR_W   = 2 * LINES;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    localparam int MCR_W   = 5;
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;
    localparam int MC_LOOP = 4;

    typedef enum logic {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } trk_state_e;
endpackage

// File: rtl/msd_status_map.sv
module msd_status_map
    import msd_pkg::*;
(
    input  logic [MCR_W-1:0] mctl,
    input  logic             line_cts,
    input  logic             line_ri,
    output logic [LINES-1:0] stat
);
    always_comb begin
        unique case (mctl[MC_LOOP])
            1'b1: begin
                stat[IDX_CTS] = mctl[MC_RTS];
                stat[IDX_DSR] = mctl[MC_DTR];
                stat[IDX_RI]  = mctl[MC_OUT1];
                stat[IDX_DCD] = mctl[MC_OUT2];
            end
            1'b0: begin
                stat[IDX_CTS] = line_cts;
                stat[IDX_DSR] = 1'b1;
                stat[IDX_RI]  = line_ri;
                stat[IDX_DCD] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/msd_delta_detect.sv
module msd_delta_detect #(
    parameter int W             = 4,
    parameter int FALL_ONLY_IDX = 2
) (
    input  logic [W-1:0] prev,
    input  logic [W-1:0] cur,
    output logic [W-1:0] flag
);
    for (genvar i = 0; i < W; i++) begin : g_line
        if (i == FALL_ONLY_IDX) begin : g_trail
            assign flag[i] = prev[i] & ~cur[i];
        end else begin : g_any
            assign flag[i] = prev[i] ^ cur[i];
        end
    end
endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl
    import msd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_rd,
    input  logic [LINES-1:0] new_stat,
    input  logic [LINES-1:0] edge_flag,
    output logic [MSR_W-1:0] msr_q
);
    trk_state_e st_q, st_d;
    logic [MSR_W-1:0] msr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_SEED;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_SEED: st_d = ST_RUN;   // SEED_TO_RUN
            ST_RUN:  st_d = ST_RUN;   // RUN_HOLD
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_SEED: msr_d = {new_stat, {LINES{1'b0}}};
            ST_RUN:  msr_d = {new_stat,
                              (stat_rd ? {LINES{1'b0}} : msr_q[LINES-1:0]) | edge_flag};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msr_q <= '0;
        else        msr_q <= msr_d;
    end

    // R1: seeding never leaves a flag behind
    assert_seed_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEED) |=> (msr_q[LINES-1:0] == '0));

    // R4: a clear-to-send change in run raises its flag
    assert_cts_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && new_stat[IDX_CTS] != msr_q[LINES+IDX_CTS]) |=> msr_q[IDX_CTS]);

    // R5: ring flag rises only with a trailing ring edge
    assert_ri_trail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr_q[IDX_RI]) |-> ($past(msr_q[LINES+IDX_RI]) && !msr_q[LINES+IDX_RI]));

    // R6: without a read, no flag is lost
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !stat_rd) |=>
        ((msr_q[LINES-1:0] & $past(msr_q[LINES-1:0])) == $past(msr_q[LINES-1:0])));

    // R7: a read with no new change leaves every flag clear
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && stat_rd && new_stat == msr_q[MSR_W-1:LINES]) |=>
        (msr_q[LINES-1:0] == '0));
endmodule

// File: rtl/msd_tracker.sv
module msd_tracker
    import msd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MCR_W-1:0] mctl_i,
    input  logic             line_cts_i,
    input  logic             line_ri_i,
    input  logic             stat_rd_i,
    output logic [MSR_W-1:0] msr_o,
    output logic             delta_pend_o
);
    logic [LINES-1:0] now_stat;
    logic [LINES-1:0] edge_flag;
    logic [MSR_W-1:0] msr_q;

    msd_status_map u_map (
        .mctl     (mctl_i),
        .line_cts (line_cts_i),
        .line_ri  (line_ri_i),
        .stat     (now_stat)
    );

    msd_delta_detect #(.W(LINES), .FALL_ONLY_IDX(IDX_RI)) u_delta (
        .prev (msr_q[MSR_W-1:LINES]),
        .cur  (now_stat),
        .flag (edge_flag)
    );

    msd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (stat_rd_i),
        .new_stat  (now_stat),
        .edge_flag (edge_flag),
        .msr_q     (msr_q)
    );

    assign msr_o        = msr_q;
    assign delta_pend_o = |msr_q[LINES-1:0];

    // R2: outside loopback the forced states read high after the edge
    assert_forced_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mctl_i[MC_LOOP] |=> (msr_o[LINES+IDX_DSR] && msr_o[LINES+IDX_DCD]));

    // R3: in loopback the control outputs appear in the status
    assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mctl_i[MC_LOOP] |=> (msr_o[LINES+IDX_CTS] == $past(mctl_i[MC_RTS]) &&
                             msr_o[LINES+IDX_DSR] == $past(mctl_i[MC_DTR]) &&
                             msr_o[LINES+IDX_RI]  == $past(mctl_i[MC_OUT1]) &&
                             msr_o[LINES+IDX_DCD] == $past(mctl_i[MC_OUT2])));
endmodule

// File: tb/msd_tracker_test.sv
module msd_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] mctl = 5'h00;
    logic       cts = 1'b0;
    logic       ri = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] msr;
    logic       pend;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_msr = 8'h00;
    bit seeding = 1'b0;

    always #10 clk = ~clk;

    msd_tracker uut (
        .clk (clk), .rst_n (rst_n), .mctl_i (mctl), .line_cts_i (cts),
        .line_ri_i (ri), .stat_rd_i (rd), .msr_o (msr), .delta_pend_o (pend)
    );

    // states {dcd, ri, dsr, cts} from requirements R2 and R3
    function automatic logic [3:0] calc_stat(logic [4:0] m, logic c, logic r);
        if (m[4]) return {m[3], m[2], m[0], m[1]};
        return {1'b1, r, 1'b1, c};
    endfunction

    function automatic logic [7:0] next_msr(logic [7:0] old, logic [3:0] s, logic rdv);
        logic [3:0] d;
        d = (rdv ? 4'h0 : old[3:0]) | ((old[7:4] ^ s) & 4'b1011) | (old[7:4] & ~s & 4'b0100);
        return {s, d};
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, expv);
        end
    endtask

    task automatic chk_pend(string tag);
        checks++;
        if (pend !== (msr[3:0] != 4'h0)) begin
            errors++;
            $display("FAIL %s: pend got %0b expected %0b", tag, pend, (msr[3:0] != 4'h0));
        end
    endtask

    // one clock: model follows at the edge, outputs sampled at the falling edge
    task automatic cycle();
        @(posedge clk);
        if (rst_n) begin
            if (seeding) begin
                exp_msr = {calc_stat(mctl, cts, ri), 4'h0};
                seeding = 1'b0;
            end else begin
                exp_msr = next_msr(exp_msr, calc_stat(mctl, cts, ri), rd);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        cts = 1'b1; ri = 1'b1; mctl = 5'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset value", msr, 8'h00);
        chk_pend("R8 reset");
        rst_n = 1'b1; seeding = 1'b1;
        cycle();
        chk("R1 seed no flags", msr, 8'hF0);
        chk("R2 forced high", msr, exp_msr);
        chk_pend("R8 seed");

        ri = 1'b0; cycle();
        chk("R5 ring trailing", msr, 8'hB4);
        chk_pend("R8 pending set");
        ri = 1'b1; cycle();
        chk("R5 R6 ring rise keeps flag", msr, 8'hF4);
        rd = 1'b1; cycle(); rd = 1'b0;
        chk("R7 read clears", msr, 8'hF0);
        chk_pend("R8 cleared");

        cts = 1'b0; rd = 1'b1; cycle();
        chk("R7 R4 change during read", msr, 8'hE1);
        cycle(); rd = 1'b0;
        chk("R7 second read", msr, 8'hE0);

        mctl = 5'h10; cycle();
        chk("R9 enter loopback", msr, 8'h0E);
        rd = 1'b1; cycle(); rd = 1'b0;
        chk("R7 clear in loop", msr, 8'h00);
        cts = 1'b1; ri = 1'b0; cycle();
        chk("R3 lines ignored", msr, 8'h00);
        ri = 1'b1; cycle();
        chk("R3 lines ignored again", msr, 8'h00);
        mctl = 5'h1F; cycle();
        chk("R3 R4 loop rise", msr, 8'hFB);
        rd = 1'b1; cycle(); rd = 1'b0;
        chk("R7 clear", msr, 8'hF0);
        mctl = 5'h1B; cycle();
        chk("R3 R5 loop ring off", msr, 8'hB4);
        mctl = 5'h0B; cycle();
        chk("R9 R6 leave loopback", msr, exp_msr);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] == 3'd0) cts = ~cts;
            if (r[5:3] == 3'd0) ri = ~ri;
            if (r[10:6] == 5'd0) mctl[4] = ~mctl[4];
            if (r[13:11] == 3'd0) mctl[3:0] = r[17:14];
            rd = (r[19:18] == 2'd0);
            cycle();
            chk("R4/R5/R6 random", msr, exp_msr);
            chk_pend("R8 random");
        end
        rd = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule